// File: doc/BRIEF.md
# Barrett Modular Reduction Pipeline

This block takes a double-width product and returns its remainder modulo a prime that is fixed when the design is elaborated. It avoids a divider. A reciprocal of the prime is computed once as a constant, and it is used to estimate the quotient from the upper half of the product. The block multiplies the estimate back by the prime and subtracts that from the product's low bits. A bank of parallel subtractions then removes the few leftover multiples of the prime.

With the prime P, let N be floor(log2 P). The input is 2N+2 bits wide and the output is N+1 bits wide. The pipeline takes one product per clock and has a fixed latency of four cycles. A valid flag travels alongside the data. The reciprocal constant is floor(2^(2N)/P). The error bound of the quotient estimate is a parameter (`MAX_ERR`, default 3), and it sets how many correction candidates are built. The internal remainder width is sized to hold `(MAX_ERR+1)*P`.

Top module: `barrett_reduce`

## Requirements
- R1: When `out_valid` is high, `rem` equals `prod mod PRIME` for the product accepted four cycles earlier, for every `prod` below PRIME squared.
- R2: A product sampled with `in_valid` high on a rising edge appears with `out_valid` high after exactly four rising edges.
- R3: Products may be offered on consecutive cycles; each one yields its own result, in order, one per cycle.
- R4: While `rst` is high, and on the cycles after it falls until an accepted product has crossed the pipeline, `out_valid` is low.
- R5: The quotient estimate never exceeds the true quotient and fits in N+1 bits. The coarse remainder is below `(MAX_ERR+1)*PRIME`.
- R6: Whenever `out_valid` is high, `rem` is below PRIME.
- R7: A cycle with `in_valid` low yields a cycle with `out_valid` low four edges later, and no other output slot is disturbed.
- R8: Corner products reduce correctly: 0 gives 0, PRIME gives 0, PRIME*(PRIME-1) gives 0, (PRIME-1)^2 gives 1, and PRIME^2-1 gives PRIME-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `prod` as a product to reduce |
| prod | input | 2N+2 | Product to reduce, below PRIME squared |
| out_valid | output | 1 | Marks `rem` as a result |
| rem | output | N+1 | Remainder in [0, PRIME-1] |

## Verification
The bench uses the Mersenne prime 2^61-1 and computes every expected remainder with a wide modulo operation. The largest products, (P-1)^2 and P^2-1, push the quotient estimate to its maximum. A design that truncated the upper half wrongly, or mis-sized the candidate bank, would return a value one or more multiples of P too large. Exact multiples of P test the boundary between two correction candidates; choosing the wrong sign-based winner returns P instead of 0. Bubbles mixed into back-to-back traffic catch a valid flag that slips a stage relative to its data, which would shift every result by a cycle.

// File: rtl/barrett_pkg.sv
package barrett_pkg;

   // floor(2^(2n) / p), computed at elaboration; 2n must stay below 128
   function automatic logic [127:0] recip_const(input logic [63:0] p, input int n);
      logic [127:0] num;
      num = 128'd1 << (2 * n);
      return num / {64'd0, p};
   endfunction

endpackage

// File: rtl/brd_quot_est.sv
module brd_quot_est #(
   parameter logic [63:0] PRIME = 64'h1FFF_FFFF_FFFF_FFFF,
   parameter int          N     = 60,
   parameter int          RW    = 63
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            v_i,
   input  logic [2*N+1:0]  prod_i,
   output logic            v_o,
   output logic [N:0]      q_o,
   output logic [RW-1:0]   lo_o
);
   localparam logic [127:0] C_WIDE = barrett_pkg::recip_const(PRIME, N);
   localparam logic [N:0]   C      = C_WIDE[N:0];
   localparam int           FW     = 2*N + 3;

   // stage 1: upper part of the product, low slice carried along
   logic            v1;
   logic [N+1:0]    hi1;
   logic [RW-1:0]   lo1;

   always_ff @(posedge clk) begin
      if (rst) v1 <= 1'b0;
      else     v1 <= v_i;
      hi1 <= prod_i[2*N+1:N];
      lo1 <= prod_i[RW-1:0];
   end

   // stage 2: multiply by the reciprocal and drop N bits
   logic [FW-1:0] full;
   logic [N+2:0]  qx;
   assign full = FW'(hi1) * FW'(C);
   assign qx   = (N+3)'(full >> N);

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v1;
      q_o  <= qx[N:0];
      lo_o <= lo1;
   end

   // estimate must fit in N+1 bits since it never exceeds the true quotient
   assert_quot_fits_R5: assert property (@(posedge clk) disable iff (rst)
      v1 |-> (qx[N+2:N+1] == 2'b00))
      else $error("quotient estimate overflow");

endmodule

// File: rtl/brd_coarse_sub.sv
module brd_coarse_sub #(
   parameter logic [63:0] PRIME   = 64'h1FFF_FFFF_FFFF_FFFF,
   parameter int          N       = 60,
   parameter int          RW      = 63,
   parameter int          MAX_ERR = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            v_i,
   input  logic [N:0]      q_i,
   input  logic [RW-1:0]   lo_i,
   output logic            v_o,
   output logic [RW-1:0]   rc_o
);
   localparam logic [RW-1:0] P_RW  = RW'(PRIME);
   localparam logic [RW:0]   LIMIT = (RW+1)'(PRIME * 64'(MAX_ERR + 1));

   // truncated back-multiply: only RW low bits of q*P matter
   logic [RW-1:0] qp;
   assign qp = RW'(q_i) * P_RW;

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
      rc_o <= lo_i - qp;
   end

   assert_err_bound_R5: assert property (@(posedge clk) disable iff (rst)
      v_o |-> ({1'b0, rc_o} < LIMIT))
      else $error("coarse remainder beyond error bound");

endmodule

// File: rtl/brd_fine_sel.sv
module brd_fine_sel #(
   parameter logic [63:0] PRIME   = 64'h1FFF_FFFF_FFFF_FFFF,
   parameter int          N       = 60,
   parameter int          RW      = 63,
   parameter int          MAX_ERR = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            v_i,
   input  logic [RW-1:0]   rc_i,
   output logic            v_o,
   output logic [N:0]      rem_o
);
   localparam int          NC  = MAX_ERR + 1;
   localparam logic [RW:0] P_W = (RW+1)'(PRIME);

   // one subtraction per candidate multiple, sign bit in position RW
   logic [RW:0] cand [NC];

   for (genvar m = 0; m < NC; m++) begin : g_cand
      localparam logic [RW:0] MP = (RW+1)'(PRIME * 64'(m));
      assign cand[m] = {1'b0, rc_i} - MP;
   end

   // largest m whose difference is non-negative wins
   logic [RW:0] sel;
   always_comb begin
      sel = cand[0];
      for (int m = 1; m < NC; m++) begin
         if (!cand[m][RW]) sel = cand[m];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) v_o <= 1'b0;
      else     v_o <= v_i;
      rem_o <= sel[N:0];
   end

   assert_sel_in_range_R6: assert property (@(posedge clk) disable iff (rst)
      v_i |-> (sel < P_W))
      else $error("selected candidate not below prime");

   assert_rem_below_prime_R6: assert property (@(posedge clk) disable iff (rst)
      v_o |-> ({{(RW-N){1'b0}}, rem_o} < P_W))
      else $error("remainder not below prime");

endmodule

// File: rtl/barrett_reduce.sv
module barrett_reduce #(
   parameter logic [63:0] PRIME   = 64'h1FFF_FFFF_FFFF_FFFF,
   parameter int          MAX_ERR = 3,
   localparam int         N       = $clog2(PRIME + 64'd1) - 1,
   localparam int         PW      = 2*N + 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [PW-1:0]   prod,
   output logic            out_valid,
   output logic [N:0]      rem
);
   localparam int RW = N + 1 + $clog2(MAX_ERR + 1);

   if (PRIME < 64'd3 || PRIME[0] == 1'b0) begin : g_bad_prime
      $error("PRIME must be an odd value of at least 3");
   end
   if (MAX_ERR < 1) begin : g_bad_err
      $error("MAX_ERR must be at least 1");
   end
   if (RW > 63) begin : g_bad_width
      $error("PRIME too wide for the internal remainder width");
   end

   logic          v2, v3;
   logic [N:0]    q2;
   logic [RW-1:0] lo2, rc3;

   brd_quot_est #(.PRIME(PRIME), .N(N), .RW(RW)) u_quot (
      .clk(clk), .rst(rst), .v_i(in_valid), .prod_i(prod),
      .v_o(v2), .q_o(q2), .lo_o(lo2)
   );

   brd_coarse_sub #(.PRIME(PRIME), .N(N), .RW(RW), .MAX_ERR(MAX_ERR)) u_coarse (
      .clk(clk), .rst(rst), .v_i(v2), .q_i(q2), .lo_i(lo2),
      .v_o(v3), .rc_o(rc3)
   );

   brd_fine_sel #(.PRIME(PRIME), .N(N), .RW(RW), .MAX_ERR(MAX_ERR)) u_fine (
      .clk(clk), .rst(rst), .v_i(v3), .rc_i(rc3),
      .v_o(out_valid), .rem_o(rem)
   );

   // edges since reset, saturating, so the latency check looks back only over clean history
   logic [2:0] warm;
   always_ff @(posedge clk) begin
      if (rst)              warm <= 3'd0;
      else if (warm != 3'd4) warm <= warm + 3'd1;
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)))
      else $error("valid latency mismatch");

   assert_reset_clears_R4: assert property (@(posedge clk)
      $past(rst) |-> !out_valid)
      else $error("out_valid high after reset");

endmodule

// File: tb/barrett_reduce_bench.sv
module barrett_reduce_bench;
   localparam logic [63:0] P  = 64'h1FFF_FFFF_FFFF_FFFF;
   localparam int          N  = 60;
   localparam int          PW = 2*N + 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [PW-1:0] prod = '0;
   logic          out_valid;
   logic [N:0]    rem;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   barrett_reduce #(.PRIME(P), .MAX_ERR(3)) u_barrett_reduce (
      .clk(clk), .rst(rst), .in_valid(in_valid), .prod(prod),
      .out_valid(out_valid), .rem(rem)
   );

   // bench model of the four-stage pipe
   logic          mv [1:4];
   logic [PW-1:0] mp [1:4];
   string         mt [1:4];

   function automatic logic [63:0] ref_mod(input logic [PW-1:0] x);
      logic [127:0] w;
      w = {{(128-PW){1'b0}}, x} % {64'd0, P};
      return w[63:0];
   endfunction

   function automatic logic [PW-1:0] mul(input logic [63:0] a, input logic [63:0] b);
      logic [127:0] w;
      w = {64'd0, a} * {64'd0, b};
      return w[PW-1:0];
   endfunction

   task automatic step(input logic v, input logic [PW-1:0] p, input string tag);
      logic [63:0] exp;
      in_valid = v;
      prod     = p;
      @(posedge clk);
      for (int i = 4; i > 1; i--) begin
         mv[i] = mv[i-1]; mp[i] = mp[i-1]; mt[i] = mt[i-1];
      end
      mv[1] = v; mp[1] = p; mt[1] = tag;
      @(negedge clk);
      checks++;
      if (out_valid !== mv[4]) begin
         errors++;
         $display("FAIL R2 R3 R7: out_valid=%0b expected %0b", out_valid, mv[4]);
      end
      if (mv[4] === 1'b1) begin
         exp = ref_mod(mp[4]);
         checks++;
         if ({3'd0, rem} !== exp) begin
            errors++;
            $display("FAIL %s: rem=%0h expected %0h", mt[4], rem, exp);
         end
      end
   endtask

   initial begin
      logic [63:0] a, b;
      void'($urandom(32'd20240611));
      for (int i = 1; i <= 4; i++) begin mv[i] = 1'b0; mp[i] = '0; mt[i] = ""; end
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R4: out_valid=%0b during reset expected 0", out_valid);
      end
      rst = 1'b0;
      // R4: idle cycles right after reset
      for (int i = 0; i < 4; i++) step(1'b0, '0, "R4");
      // R8 corners, back to back (R3)
      step(1'b1, '0, "R8 zero");
      step(1'b1, PW'(P), "R8 prime");
      step(1'b1, mul(P, P - 64'd1), "R8 P*(P-1)");
      step(1'b1, mul(P - 64'd1, P - 64'd1), "R8 (P-1)^2");
      step(1'b1, mul(P, P) - PW'(1), "R8 P^2-1");
      step(1'b1, PW'(1), "R8 one");
      step(1'b1, PW'(P - 64'd1), "R8 P-1");
      // R7: bubbles
      for (int i = 0; i < 5; i++) step(1'b0, mul(P - 64'd1, P - 64'd1), "R7");
      step(1'b1, mul(64'd2, P), "R8 2P");
      step(1'b0, '0, "R7");
      step(1'b1, mul(P - 64'd1, 64'd2), "R8 2(P-1)");
      // R1 R5 R6: random products with occasional bubbles
      for (int i = 0; i < 3000; i++) begin
         a = {$urandom(), $urandom()} % P;
         b = {$urandom(), $urandom()} % P;
         if (i % 97 == 0) a = P - 64'd1 - 64'(i % 5);
         step(($urandom() % 4) != 0, mul(a, b), "R1 R5 R6");
      end
      for (int i = 0; i < 6; i++) step(1'b0, '0, "R7 drain");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule